// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes into asynchronous serial characters on a single output line. Software-style configuration inputs set the character format and the bit rate: a 16-bit time constant, a clock-mode divisor code, a data-length code, parity enable and sense, and a stop-bit code. The bit time is derived from the block clock, which acts as the fixed reference: one bit lasts (time constant + 2) reference cycles, multiplied by 1, 16, 32 or 64.

A one-byte holding buffer sits in front of the shift engine. A byte written while a character is on the line waits there, and the engine picks it up right after the last stop bit of the current character, with no idle gap. Two flags report progress: buffer-empty, which says the holding buffer can take another byte, and all-sent, which says the line has finished every character and is idle. The whole format, including the bit time, is captured when a character starts. A change to the configuration therefore never disturbs a character that is already on the line.

Top module: `async_tx_engine`

## Requirements
- R1: After reset, txd is 1, buf_empty is 1 and all_sent is 1.
- R2: Every bit on txd lasts (cfg_tconst + 2) * D clock cycles. D is 1, 16, 32 or 64 for cfg_clkmode codes 00, 01, 10 and 11.
- R3: The line idles at 1. A character is a start bit of 0, then the data bits with the least significant bit first, then the optional parity bit, then the stop bits at 1.
- R4: cfg_wlen selects the number of data bits: 00 gives 5, 01 gives 7, 10 gives 6 and 11 gives 8.
- R5: When cfg_par_en is 1, a parity bit follows the data. If cfg_par_even is 1, the data bits and the parity bit together hold an even number of ones. If it is 0, they hold an odd number. When cfg_par_en is 0, no parity bit is sent.
- R6: cfg_stop equal to 11 gives two stop bits. Every other code gives one stop bit.
- R7: A write with cfg_tx_en at 0 is ignored. A held byte does not start while cfg_tx_en is 0. A character already on the line always completes.
- R8: Once the engine is idle and enabled, a byte written to an empty holding buffer starts its start bit one cycle after the write. The buf_empty flag is 0 from the cycle after the write until the cycle after the engine takes the byte. A byte waiting behind a busy engine starts in the cycle right after the previous character's last stop bit.
- R9: all_sent goes to 0 when a start bit begins. It returns to 1 when the last stop bit ends and no byte is waiting.
- R10: The format and the bit time are sampled when a character's start bit begins. Configuration changes during the character do not affect that character.
- R11: A write while the holding buffer is full replaces the held byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tconst | input | 16 | Bit-rate time constant |
| cfg_clkmode | input | 2 | Extra divide code (1/16/32/64) |
| cfg_wlen | input | 2 | Data-length code |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop | input | 2 | Stop-bit code (11 = two stop bits) |
| cfg_tx_en | input | 1 | Transmit enable |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial line output |
| buf_empty | output | 1 | Holding buffer can accept a byte |
| all_sent | output | 1 | Line idle with nothing pending |

## Verification
The hardest cases to reach are the ones where several events fall on the same clock edge. One is a second byte waiting when the last stop bit ends. Another is a write landing on the same edge on which the engine takes the held byte. A third is a change of enable or format while a character is on the line. The stimulus reaches these by issuing back-to-back writes on consecutive cycles and by toggling the enable a set number of cycles after a write. It also rewrites the configuration part-way through a character. A behavioural queue model follows every cycle, so any shift in a bit boundary or in a flag shows up at the exact cycle where it happens.

// File: rtl/atx_pkg.sv
package atx_pkg;
    localparam int TC_W    = 16;
    localparam int DATA_W  = 8;
    localparam int STOP_MAX = 2;
    localparam int FRAME_W = 1 + DATA_W + 1 + STOP_MAX;
    localparam int IDX_W   = $clog2(FRAME_W + 1);
    localparam int CNT_W   = TC_W + 7;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [IDX_W-1:0]   nbits;
        logic [CNT_W-1:0]   period;
    } frame_t;

    function automatic int unsigned data_len(input logic [1:0] code);
        case (code)
            2'b00:   return 5;
            2'b01:   return 7;
            2'b10:   return 6;
            default: return 8;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] bit_period(input logic [TC_W-1:0] tc,
                                                    input logic [1:0] mode);
        logic [CNT_W-1:0] base;
        base = CNT_W'(tc) + CNT_W'(2);
        case (mode)
            2'b00:   return base;
            2'b01:   return base << 4;
            2'b10:   return base << 5;
            default: return base << 6;
        endcase
    endfunction
endpackage

// File: rtl/atx_framer.sv
module atx_framer
    import atx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [TC_W-1:0]   tconst,
    input  logic [1:0]        clkmode,
    input  logic [1:0]        wlen,
    input  logic              par_en,
    input  logic              par_even,
    input  logic [1:0]        stop,
    output frame_t            frame
);
    always_comb begin
        int unsigned len;
        int unsigned pos;
        logic        ones;
        len  = data_len(wlen);
        ones = 1'b0;
        frame.bits = '1;
        frame.bits[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(len)) begin
                frame.bits[1+i] = data[i];
                ones = ones ^ data[i];
            end
        end
        pos = 1 + len;
        if (par_en) begin
            frame.bits[pos] = par_even ? ones : ~ones;
            pos = pos + 1;
        end
        pos = pos + ((stop == 2'b11) ? 2 : 1);
        frame.nbits  = IDX_W'(pos);
        frame.period = bit_period(tconst, clkmode);
    end
endmodule

// File: rtl/atx_holdbuf.sv
module atx_holdbuf
    import atx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (take)
                full <= 1'b0;
            if (wr_valid && tx_en) begin
                full <= 1'b1;
                data <= wr_data;
            end
        end
    end

    p_write_fills_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && tx_en) |=> (full && data == $past(wr_data)));
    p_disabled_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> ($stable(full) && $stable(data)));
endmodule

// File: rtl/atx_shifter.sv
module atx_shifter
    import atx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ready,
    input  frame_t next_frame,
    output logic   take,
    output logic   txd,
    output logic   all_sent
);
    frame_t           cur;
    logic             busy;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt;
    logic             bit_done;
    logic             last_done;

    assign bit_done  = busy && (cnt == '0);
    assign last_done = bit_done && (idx == cur.nbits - IDX_W'(1));
    assign take      = ready && (!busy || last_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            busy     <= 1'b0;
            idx      <= '0;
            cnt      <= '0;
            txd      <= 1'b1;
            all_sent <= 1'b1;
        end else if (take) begin
            cur      <= next_frame;
            busy     <= 1'b1;
            idx      <= '0;
            cnt      <= next_frame.period - CNT_W'(1);
            txd      <= next_frame.bits[0];
            all_sent <= 1'b0;
        end else if (last_done) begin
            busy     <= 1'b0;
            txd      <= 1'b1;
            all_sent <= 1'b1;
        end else if (bit_done) begin
            idx <= idx + IDX_W'(1);
            txd <= cur.bits[idx + IDX_W'(1)];
            cnt <= cur.period - CNT_W'(1);
        end else if (busy) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    p_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);
    p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
        take |=> (!txd && !all_sent));
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx < cur.nbits));
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < cur.period));
    p_allsent_idle_r9: assert property (@(posedge clk) disable iff (rst)
        all_sent |-> !busy);
endmodule

// File: rtl/async_tx_engine.sv
module async_tx_engine
    import atx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TC_W-1:0]   cfg_tconst,
    input  logic [1:0]        cfg_clkmode,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic [1:0]        cfg_stop,
    input  logic              cfg_tx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              buf_empty,
    output logic              all_sent
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    frame_t            next_frame;

    atx_holdbuf u_hold (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (cfg_tx_en),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .full     (hold_full),
        .data     (hold_data)
    );

    atx_framer u_framer (
        .data     (hold_data),
        .tconst   (cfg_tconst),
        .clkmode  (cfg_clkmode),
        .wlen     (cfg_wlen),
        .par_en   (cfg_par_en),
        .par_even (cfg_par_even),
        .stop     (cfg_stop),
        .frame    (next_frame)
    );

    atx_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .ready      (hold_full && cfg_tx_en),
        .next_frame (next_frame),
        .take       (take),
        .txd        (txd),
        .all_sent   (all_sent)
    );

    assign buf_empty = !hold_full;

    p_take_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
        (take |-> (cfg_tx_en && !buf_empty)));
endmodule

// File: tb/async_tx_engine_test.sv
module async_tx_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_tconst = '0;
    logic [1:0]  cfg_clkmode = '0;
    logic [1:0]  cfg_wlen = 2'b11;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_even = 1'b0;
    logic [1:0]  cfg_stop = '0;
    logic        cfg_tx_en = 1'b1;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        txd, buf_empty, all_sent;

    always #2 clk = ~clk;

    async_tx_engine uut (.*);

    int    n_chk = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string phase = "R1 reset";
    bit    cmp_on = 1'b0;

    // behavioural model
    int  q[$];
    int  m_rem, m_period;
    bit  m_full, m_txd, m_all;
    int  m_hold;

    function automatic int len_of(input logic [1:0] c);
        return (c == 2'b00) ? 5 : (c == 2'b01) ? 7 : (c == 2'b10) ? 6 : 8;
    endfunction

    function automatic int div_of(input logic [1:0] c);
        return (c == 2'b00) ? 1 : (c == 2'b01) ? 16 : (c == 2'b10) ? 32 : 64;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            q.delete();
            m_full = 0; m_txd = 1; m_all = 1; m_rem = 0; m_hold = 0; m_period = 2;
        end else begin
            bit fin;
            int ones;
            fin = 0;
            if (q.size() > 0) begin
                m_rem--;
                if (m_rem == 0) begin
                    void'(q.pop_front());
                    if (q.size() == 0) fin = 1;
                    else begin m_txd = q[0][0]; m_rem = m_period; end
                end
            end
            if (m_full && cfg_tx_en && q.size() == 0) begin
                ones = 0;
                q.push_back(0);
                for (int i = 0; i < len_of(cfg_wlen); i++) begin
                    q.push_back((m_hold >> i) & 1);
                    ones += (m_hold >> i) & 1;
                end
                if (cfg_par_en) q.push_back(cfg_par_even ? (ones % 2) : 1 - (ones % 2));
                q.push_back(1);
                if (cfg_stop == 2'b11) q.push_back(1);
                m_period = (int'(cfg_tconst) + 2) * div_of(cfg_clkmode);
                m_rem = m_period;
                m_txd = 0; m_all = 0; m_full = 0;
            end else if (fin) begin
                m_txd = 1; m_all = 1;
            end
            if (wr_valid && cfg_tx_en) begin
                m_full = 1; m_hold = wr_data;
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            check(phase, txd, m_txd, "txd");
            check(phase, buf_empty, !m_full, "buf_empty");
            check(phase, all_sent, m_all, "all_sent");
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() > 0 || m_full) @(negedge clk);
        tick(3);
    endtask

    task automatic fmt(input logic [15:0] tc, input logic [1:0] md, input logic [1:0] wl,
                       input logic pe, input logic pv, input logic [1:0] st);
        cfg_tconst = tc; cfg_clkmode = md; cfg_wlen = wl;
        cfg_par_en = pe; cfg_par_even = pv; cfg_stop = st;
    endtask

    initial begin
        tick(3);
        check("R1", txd, 1'b1, "reset txd");
        check("R1", buf_empty, 1'b1, "reset buf_empty");
        check("R1", all_sent, 1'b1, "reset all_sent");
        rst = 1'b0;
        cmp_on = 1'b1;
        tick(2);

        phase = "R2 R3 R4 8N1";
        fmt(16'd0, 2'b00, 2'b11, 0, 0, 2'b00); send(8'hA5); wait_idle();
        phase = "R4 R5 7E1";
        fmt(16'd1, 2'b00, 2'b01, 1, 1, 2'b00); send(8'h3C); wait_idle();
        phase = "R5 R6 6O2";
        fmt(16'd3, 2'b00, 2'b10, 1, 0, 2'b11); send(8'h2B); wait_idle();
        phase = "R6 stop code 10 one stop";
        fmt(16'd0, 2'b00, 2'b11, 0, 0, 2'b10); send(8'h81); wait_idle();
        phase = "R2 R4 5N1 div16";
        fmt(16'd1, 2'b01, 2'b00, 0, 0, 2'b00); send(8'h1F); wait_idle();
        phase = "R2 div32";
        fmt(16'd0, 2'b10, 2'b00, 1, 1, 2'b00); send(8'h15); wait_idle();
        phase = "R2 div64";
        fmt(16'd0, 2'b11, 2'b00, 0, 0, 2'b00); send(8'h0A); wait_idle();

        phase = "R8 R9 back-to-back";
        fmt(16'd1, 2'b00, 2'b11, 0, 0, 2'b00);
        send(8'h11); send(8'h22); send(8'h5A); tick(40); send(8'hC3); wait_idle();

        phase = "R11 overwrite";
        @(negedge clk); wr_valid = 1; wr_data = 8'h33;
        @(negedge clk); wr_data = 8'h44;
        @(negedge clk); wr_data = 8'h55;
        @(negedge clk); wr_valid = 0;
        wait_idle();

        phase = "R7 write while disabled";
        cfg_tx_en = 1'b0; send(8'h66); tick(20); cfg_tx_en = 1'b1; tick(10);

        phase = "R7 held byte waits";
        @(negedge clk); wr_valid = 1; wr_data = 8'h99;
        @(negedge clk); wr_valid = 0; cfg_tx_en = 0;
        tick(25); cfg_tx_en = 1; wait_idle();

        phase = "R7 disable mid-character";
        send(8'hE7); tick(5); cfg_tx_en = 0; tick(60); cfg_tx_en = 1; wait_idle();

        phase = "R10 config change mid-character";
        fmt(16'd2, 2'b00, 2'b11, 0, 0, 2'b00); send(8'h6D); tick(10);
        fmt(16'd0, 2'b00, 2'b00, 1, 1, 2'b11); wait_idle();
        send(8'h6D); wait_idle();

        cmp_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired in phase %s", phase);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule